// File: doc/BRIEF.md
# Fully Associative Address Translation Cache with Superpages

This block is a small translation cache that sits between a core's load/store path and memory. Each lookup presents a virtual address, an address-space tag and an access kind (read, write or execute). Every stored mapping is compared at the same time. The registered response comes back one cycle later and takes one of three forms:

- a physical address;
- a miss, so that the surrounding logic can fetch the mapping from the page tables;
- a fault, when a mapping exists but does not allow the access.

Mappings are installed through a separate fill port at an index chosen by the caller. Two flush controls remove stale mappings: one removes every mapping, and the other removes only the mappings of a single address space.

The base page is 4 KB. Each mapping carries a size code `s`, and the mapping then spans 2^s base pages. Both the virtual and the physical range of such a mapping are contiguous and aligned to the mapping's own span. For that mapping the low `s` bits of the virtual page number are left out of the compare, and those same bits are copied from the virtual address into the physical page number. Each slot also records whether it has been used (referenced) and whether it has been written (modified). The response reports both bits.

Top module: `tlb_sp`

## Requirements
- R1: While reset is high and after it is released, every slot is invalid and `rsp_valid`, `rsp_hit`, `rsp_miss`, `rsp_fault`, `rsp_pa`, `rsp_ref` and `rsp_mod` are zero until a lookup is made. The first lookup after reset is a miss.
- R2: A lookup presented with `req_valid` high produces `rsp_valid` high on the following cycle. Exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is then set. When no lookup was presented, all three are zero.
- R3: A slot matches only if it is valid, its address-space tag equals `req_asid`, and its virtual page tag equals `req_va[31:12]` on every bit that the size code does not mask. A lookup with no matching slot is a miss, with `rsp_pa`, `rsp_ref` and `rsp_mod` at zero.
- R4: On a hit with size code 0, `rsp_pa` is the slot's 20-bit physical page number followed by `req_va[11:0]`.
- R5: With size code s (0 to 7), bits s-1:0 of the virtual page number are not compared. On a hit those bits of the physical page number come from `req_va`, and the upper bits come from the slot. An address just past the end of the superpage misses.
- R6: Access codes are 0 = read, 1 = write, 2 = execute and 3 = reserved. Protection codes are 0 = read only, 1 = execute only, 2 = read and write, and 3 = no access. An access that the matching slot's protection does not allow (the reserved code always counts as not allowed) gives a fault with `rsp_pa` zero.
- R7: On a hit or a fault, `rsp_ref` and `rsp_mod` show the slot's bits as they were before that lookup. A permitted hit sets the referenced bit. A permitted write also sets the modified bit. A fault changes neither bit.
- R8: A fill writes all fields of slot `fill_idx`, marks the slot valid and clears its referenced and modified bits. A lookup in the same cycle as a fill sees the newly written slot.
- R9: `flush_all` invalidates every slot, so that lookups from the next cycle on miss until slots are filled again.
- R10: `flush_asid_en` invalidates only the slots whose address-space tag equals `flush_asid`. The other slots keep translating.
- R11: When more than one slot matches, the slot with the lowest index supplies the response and receives the bit updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A lookup is presented this cycle |
| req_va | input | 32 | Virtual address to translate |
| req_asid | input | 8 | Address-space tag of the lookup |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| fill_en | input | 1 | Write a slot this cycle |
| fill_idx | input | 4 | Slot to write |
| fill_vpn | input | 20 | Virtual page tag of the new slot |
| fill_asid | input | 8 | Address-space tag of the new slot |
| fill_ppn | input | 20 | Physical page number of the new slot |
| fill_size | input | 3 | Size code: the mapping spans 2^size base pages |
| fill_prot | input | 2 | Protection: 0 read only, 1 execute only, 2 read/write, 3 none |
| flush_all | input | 1 | Invalidate every slot |
| flush_asid_en | input | 1 | Invalidate the slots that carry `flush_asid` |
| flush_asid | input | 8 | Address-space tag to flush |
| rsp_valid | output | 1 | Response to the previous cycle's lookup |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No slot matched |
| rsp_fault | output | 1 | A slot matched but forbids the access |
| rsp_pa | output | 32 | Physical address on a hit, otherwise zero |
| rsp_ref | output | 1 | Referenced bit of the matched slot before the lookup |
| rsp_mod | output | 1 | Modified bit of the matched slot before the lookup |

## Verification
The bench targets the following corner cases:

- **Superpage edges.** An offset deep inside an 8-page superpage must translate. A design that compared all tag bits would miss there. The first page beyond the superpage must miss. A design that masked one bit too many would hit there.
- **Overlapping slots.** The lowest index must win. A design with the wrong priority would return the other physical page.
- **Fill and lookup in the same cycle.** The new mapping must hit. A design that looked up before writing the slot would report a miss or the old translation.
- **Permissions.** Every combination of protection and access code is tried. Two follow-up lookups then check that a fault left the referenced and modified bits untouched and that a write set the modified bit.
- **Address-space flush.** The bench checks that the flush keeps the slots of other address spaces.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    parameter int VA_W   = 32;
    parameter int PA_W   = 32;
    parameter int OFS_W  = 12;
    parameter int ASID_W = 8;
    parameter int SZ_W   = 3;

    localparam int VPN_W = VA_W - OFS_W;
    localparam int PPN_W = PA_W - OFS_W;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_RSV = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        PR_RO   = 2'd0,
        PR_XO   = 2'd1,
        PR_RW   = 2'd2,
        PR_NONE = 2'd3
    } prot_e;

    typedef struct packed {
        logic              vld;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vtag;
        logic [PPN_W-1:0]  ppn;
        logic [SZ_W-1:0]   sz;
        prot_e             prot;
        logic              refd;
        logic              mod;
    } ent_t;

    // Bits of the virtual page number that take part in the compare
    function automatic logic [VPN_W-1:0] vmask(input logic [SZ_W-1:0] sz);
        return ~((VPN_W'(1) << sz) - VPN_W'(1));
    endfunction

    // Bits of the physical page number taken from the slot
    function automatic logic [PPN_W-1:0] pmask(input logic [SZ_W-1:0] sz);
        return ~((PPN_W'(1) << sz) - PPN_W'(1));
    endfunction

    function automatic logic allowed(input prot_e p, input acc_e a);
        logic ok;
        case (p)
            PR_RO:   ok = (a == ACC_RD);
            PR_XO:   ok = (a == ACC_EX);
            PR_RW:   ok = (a == ACC_RD) || (a == ACC_WR);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/tlb_slot.sv
module tlb_slot
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_hit,
    input  ent_t              fill_ent,
    input  logic              flush_all,
    input  logic              flush_asid_en,
    input  logic [ASID_W-1:0] flush_asid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              upd_ref,
    input  logic              upd_mod,
    output ent_t              eff,
    output logic              match
);

    ent_t cur, nxt;

    // A fill in the same cycle is visible to the lookup
    assign eff   = fill_hit ? fill_ent : cur;
    assign match = eff.vld && (eff.asid == lk_asid) &&
                   (((eff.vtag ^ lk_vpn) & vmask(eff.sz)) == '0);

    always_comb begin
        nxt = cur;
        if (flush_all || (flush_asid_en && cur.asid == flush_asid))
            nxt.vld = 1'b0;
        if (fill_hit)
            nxt = fill_ent;
        if (upd_ref)
            nxt.refd = 1'b1;
        if (upd_mod)
            nxt.mod = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

endmodule

// File: rtl/tlb_pick.sv
module tlb_pick
    import tlb_pkg::*;
#(
    parameter  int N     = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0] match,
    input  ent_t [N-1:0] ents,
    output logic         any,
    output logic [IDX_W-1:0] sel,
    output ent_t         sel_ent
);

    // Lowest matching index wins
    always_comb begin
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) sel = IDX_W'(i);
        end
        any     = |match;
        sel_ent = ents[sel];
    end

endmodule

// File: rtl/tlb_sp.sv
module tlb_sp
    import tlb_pkg::*;
#(
    parameter  int N_ENTRIES = 16,
    localparam int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [1:0]        req_acc,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [SZ_W-1:0]   fill_size,
    input  logic [1:0]        fill_prot,
    input  logic              flush_all,
    input  logic              flush_asid_en,
    input  logic [ASID_W-1:0] flush_asid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_ref,
    output logic              rsp_mod
);

    ent_t                   fill_ent;
    ent_t [N_ENTRIES-1:0]   eff_vec;
    logic [N_ENTRIES-1:0]   match_vec;
    logic [N_ENTRIES-1:0]   upd_ref;
    logic [N_ENTRIES-1:0]   upd_mod;
    logic                   any;
    logic [IDX_W-1:0]       sel;
    ent_t                   sel_ent;
    logic [VPN_W-1:0]       vpn;
    acc_e                   acc;
    logic                   perm_ok, lk_hit, lk_fault, lk_miss;
    logic [PPN_W-1:0]       pa_page;

    assign vpn = req_va[VA_W-1:OFS_W];
    assign acc = acc_e'(req_acc);

    always_comb begin
        fill_ent      = '0;
        fill_ent.vld  = 1'b1;
        fill_ent.asid = fill_asid;
        fill_ent.vtag = fill_vpn;
        fill_ent.ppn  = fill_ppn;
        fill_ent.sz   = fill_size;
        fill_ent.prot = prot_e'(fill_prot);
    end

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
        tlb_slot u_slot (
            .clk           (clk),
            .rst           (rst),
            .fill_hit      (fill_en && (fill_idx == IDX_W'(g))),
            .fill_ent      (fill_ent),
            .flush_all     (flush_all),
            .flush_asid_en (flush_asid_en),
            .flush_asid    (flush_asid),
            .lk_vpn        (vpn),
            .lk_asid       (req_asid),
            .upd_ref       (upd_ref[g]),
            .upd_mod       (upd_mod[g]),
            .eff           (eff_vec[g]),
            .match         (match_vec[g])
        );
        assign upd_ref[g] = lk_hit && (sel == IDX_W'(g));
        assign upd_mod[g] = lk_hit && (acc == ACC_WR) && (sel == IDX_W'(g));
    end

    tlb_pick #(.N(N_ENTRIES)) u_pick (
        .match   (match_vec),
        .ents    (eff_vec),
        .any     (any),
        .sel     (sel),
        .sel_ent (sel_ent)
    );

    assign perm_ok  = allowed(sel_ent.prot, acc);
    assign lk_hit   = req_valid && any && perm_ok;
    assign lk_fault = req_valid && any && !perm_ok;
    assign lk_miss  = req_valid && !any;
    assign pa_page  = (sel_ent.ppn & pmask(sel_ent.sz)) |
                      (PPN_W'(vpn) & ~pmask(sel_ent.sz));

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_pa    <= '0;
            rsp_ref   <= 1'b0;
            rsp_mod   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= lk_hit;
            rsp_miss  <= lk_miss;
            rsp_fault <= lk_fault;
            rsp_pa    <= lk_hit ? {pa_page, req_va[OFS_W-1:0]} : '0;
            rsp_ref   <= (lk_hit || lk_fault) && sel_ent.refd;
            rsp_mod   <= (lk_hit || lk_fault) && sel_ent.mod;
        end
    end

endmodule

// File: rtl/tlb_sp_chk.sv
module tlb_sp_chk
    import tlb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [VA_W-1:0]   req_va,
    input logic              fill_en,
    input logic              flush_all,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_miss,
    input logic              rsp_fault,
    input logic [PA_W-1:0]   rsp_pa,
    input logic              rsp_ref,
    input logic              rsp_mod
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !rsp_valid && !rsp_hit && !rsp_miss && !rsp_fault);

    // R2
    resp_follows_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !rsp_hit && !rsp_miss && !rsp_fault);

    // R3
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> rsp_pa == '0 && !rsp_ref && !rsp_mod);

    // R4
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!rsp_hit || rsp_pa[OFS_W-1:0] == $past(req_va[OFS_W-1:0])));

    // R6
    fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> rsp_pa == '0);

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(flush_all, 2) && !$past(fill_en, 2) && !$past(fill_en, 1)
         && !$past(rst, 2)) |-> rsp_miss);

endmodule

bind tlb_sp tlb_sp_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_va    (req_va),
    .fill_en   (fill_en),
    .flush_all (flush_all),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_fault (rsp_fault),
    .rsp_pa    (rsp_pa),
    .rsp_ref   (rsp_ref),
    .rsp_mod   (rsp_mod)
);

// File: tb/tlb_sp_tb_top.sv
`timescale 1ns/1ps
module tlb_sp_tb_top;

    localparam int CLK_NS = 20;
    localparam int NE     = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_va;
    logic [7:0]  req_asid;
    logic [1:0]  req_acc;
    logic        fill_en;
    logic [3:0]  fill_idx;
    logic [19:0] fill_vpn;
    logic [7:0]  fill_asid;
    logic [19:0] fill_ppn;
    logic [2:0]  fill_size;
    logic [1:0]  fill_prot;
    logic        flush_all;
    logic        flush_asid_en;
    logic [7:0]  flush_asid;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_ref, rsp_mod;
    logic [31:0] rsp_pa;

    int errors = 0;
    int checks = 0;

    // bench-side mapping table
    logic        m_v    [NE];
    logic [7:0]  m_asid [NE];
    logic [19:0] m_vpn  [NE];
    logic [19:0] m_ppn  [NE];
    logic [2:0]  m_sz   [NE];
    logic [1:0]  m_prot [NE];
    logic        m_ref  [NE];
    logic        m_mod  [NE];

    always #(CLK_NS/2) clk = ~clk;

    tlb_sp dut_i (.*);

    initial begin
        #(CLK_NS * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic logic perm(input logic [1:0] p, input logic [1:0] a);
        case (p)
            2'd0:    return a == 2'd0;
            2'd1:    return a == 2'd2;
            2'd2:    return a == 2'd0 || a == 2'd1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [19:0] keep_bits(input logic [2:0] s);
        logic [19:0] k = '1;
        for (int b = 0; b < 8; b++) if (b < s) k[b] = 1'b0;
        return k;
    endfunction

    // exp layout: {valid, hit, miss, fault, pa[31:0], ref, mod}
    function automatic logic [37:0] model_lookup(input logic [31:0] va, input logic [7:0] asid,
                                                 input logic [1:0] acc);
        int f = -1;
        logic [19:0] vpn = va[31:12];
        logic [19:0] k;
        logic [37:0] e;
        for (int i = 0; i < NE; i++) begin
            k = keep_bits(m_sz[i]);
            if (f < 0 && m_v[i] && m_asid[i] == asid && ((m_vpn[i] ^ vpn) & k) == 0) f = i;
        end
        if (f < 0) begin
            e = {1'b1, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0};
        end else if (!perm(m_prot[f], acc)) begin
            e = {1'b1, 1'b0, 1'b0, 1'b1, 32'h0, m_ref[f], m_mod[f]};
        end else begin
            k = keep_bits(m_sz[f]);
            e = {1'b1, 1'b1, 1'b0, 1'b0, (m_ppn[f] & k) | (vpn & ~k), va[11:0], m_ref[f], m_mod[f]};
            m_ref[f] = 1'b1;
            if (acc == 2'd1) m_mod[f] = 1'b1;
        end
        return e;
    endfunction

    task automatic check(input string req, input logic [37:0] got, input logic [37:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic [37:0] outs();
        return {rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_pa, rsp_ref, rsp_mod};
    endfunction

    task automatic set_fill(input int idx, input logic [19:0] vpn, input logic [7:0] asid,
                            input logic [19:0] ppn, input logic [2:0] sz, input logic [1:0] prot);
        fill_en = 1'b1; fill_idx = 4'(idx); fill_vpn = vpn; fill_asid = asid;
        fill_ppn = ppn; fill_size = sz; fill_prot = prot;
        m_v[idx] = 1'b1; m_asid[idx] = asid; m_vpn[idx] = vpn; m_ppn[idx] = ppn;
        m_sz[idx] = sz; m_prot[idx] = prot; m_ref[idx] = 1'b0; m_mod[idx] = 1'b0;
    endtask

    task automatic fill(input int idx, input logic [19:0] vpn, input logic [7:0] asid,
                        input logic [19:0] ppn, input logic [2:0] sz, input logic [1:0] prot);
        @(negedge clk);
        set_fill(idx, vpn, asid, ppn, sz, prot);
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] acc,
                          input string req);
        logic [37:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_asid = asid; req_acc = acc;
        e = model_lookup(va, asid, acc);
        @(negedge clk);
        req_valid = 1'b0;
        check(req, outs(), e);
    endtask

    // R8: fill and lookup in one cycle, fill applied first
    task automatic fill_and_lookup(input int idx, input logic [19:0] vpn, input logic [19:0] ppn,
                                   input logic [31:0] va);
        logic [37:0] e;
        @(negedge clk);
        set_fill(idx, vpn, 8'd1, ppn, 3'd0, 2'd2);
        req_valid = 1'b1; req_va = va; req_asid = 8'd1; req_acc = 2'd0;
        e = model_lookup(va, 8'd1, 2'd0);
        @(negedge clk);
        fill_en = 1'b0; req_valid = 1'b0;
        check("R8 same-cycle fill", outs(), e);
    endtask

    task automatic do_flush_all();
        @(negedge clk);
        flush_all = 1'b1;
        for (int i = 0; i < NE; i++) m_v[i] = 1'b0;
        @(negedge clk);
        flush_all = 1'b0;
    endtask

    task automatic do_flush_asid(input logic [7:0] a);
        @(negedge clk);
        flush_asid_en = 1'b1; flush_asid = a;
        for (int i = 0; i < NE; i++) if (m_asid[i] == a) m_v[i] = 1'b0;
        @(negedge clk);
        flush_asid_en = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; req_valid = 0; req_va = 0; req_asid = 0; req_acc = 0;
        fill_en = 0; fill_idx = 0; fill_vpn = 0; fill_asid = 0; fill_ppn = 0;
        fill_size = 0; fill_prot = 0; flush_all = 0; flush_asid_en = 0; flush_asid = 0;
        for (int i = 0; i < NE; i++) begin
            m_v[i] = 0; m_asid[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0;
            m_sz[i] = 0; m_prot[i] = 0; m_ref[i] = 0; m_mod[i] = 0;
        end
        repeat (3) @(negedge clk);
        check("R1 outputs in reset", outs(), 38'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 outputs after reset", outs(), 38'h0);
        lookup(32'h0000_0000, 8'd0, 2'd0, "R1 first lookup misses");

        // base page
        fill(0, 20'h12345, 8'd1, 20'hABCDE, 3'd0, 2'd2);
        lookup(32'h1234_5678, 8'd1, 2'd0, "R4 base translate");
        lookup(32'h1234_5FFF, 8'd1, 2'd1, "R7 write after read, ref set");
        lookup(32'h1234_5000, 8'd1, 2'd0, "R7 modified bit set");
        lookup(32'h1234_5678, 8'd2, 2'd0, "R3 other asid misses");
        lookup(32'h1234_6678, 8'd1, 2'd0, "R3 neighbour page misses");

        // superpage of 8 pages
        fill(1, 20'h40000, 8'd1, 20'h80200, 3'd3, 2'd0);
        lookup(32'h4000_5ABC, 8'd1, 2'd0, "R5 inside superpage");
        lookup(32'h4000_7FFF, 8'd1, 2'd0, "R5 last byte of superpage");
        lookup(32'h4000_8000, 8'd1, 2'd0, "R5 past superpage misses");
        lookup(32'h4000_3000, 8'd1, 2'd1, "R6 write to read-only faults");

        // permissions
        fill(2, 20'h00100, 8'd1, 20'h00777, 3'd0, 2'd1);
        fill(3, 20'h00200, 8'd1, 20'h00888, 3'd0, 2'd3);
        lookup(32'h0010_0010, 8'd1, 2'd0, "R6 read exec-only faults");
        lookup(32'h0010_0010, 8'd1, 2'd2, "R7 fault left ref clear");
        lookup(32'h0020_0010, 8'd1, 2'd0, "R6 no-access faults");
        lookup(32'h1234_5000, 8'd1, 2'd3, "R6 reserved access faults");
        for (int p = 0; p < 4; p++) begin
            for (int a = 0; a < 4; a++) begin
                fill(9, 20'h0F000, 8'd3, 20'h0E000, 3'd0, 2'(p));
                lookup(32'h0F00_0123, 8'd3, 2'(a), "R6 permission matrix");
            end
        end

        // overlapping slots
        fill(5, 20'h30000, 8'd1, 20'h11111, 3'd0, 2'd2);
        fill(4, 20'h30000, 8'd1, 20'h22222, 3'd0, 2'd2);
        lookup(32'h3000_0444, 8'd1, 2'd1, "R11 lowest index wins");
        lookup(32'h3000_0444, 8'd1, 2'd0, "R11 update went to lowest index");

        // fill together with lookup
        fill_and_lookup(6, 20'h50000, 20'h33333, 32'h5000_0123);
        fill_and_lookup(0, 20'h60000, 20'h44444, 32'h6000_0001);
        lookup(32'h1234_5678, 8'd1, 2'd0, "R8 overwritten slot gone");

        // per-asid flush
        fill(7, 20'h70000, 8'd2, 20'h55555, 3'd0, 2'd2);
        lookup(32'h7000_0000, 8'd2, 2'd0, "R10 asid 2 present");
        do_flush_asid(8'd2);
        lookup(32'h7000_0000, 8'd2, 2'd0, "R10 asid 2 flushed");
        lookup(32'h4000_1000, 8'd1, 2'd0, "R10 asid 1 kept");

        do_flush_all();
        lookup(32'h4000_1000, 8'd1, 2'd0, "R9 all flushed");
        lookup(32'h5000_0123, 8'd1, 2'd0, "R9 all flushed");

        // random phase
        for (int n = 0; n < 600; n++) begin
            int r = $urandom_range(0, 9);
            if (r < 3) begin
                fill($urandom_range(0, NE - 1), 20'($urandom_range(0, 31)), 8'($urandom_range(1, 2)),
                     20'($urandom), 3'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
            end else if (r == 3 && $urandom_range(0, 9) == 0) begin
                do_flush_asid(8'($urandom_range(1, 2)));
            end else begin
                lookup({20'($urandom_range(0, 31)), 12'($urandom)}, 8'($urandom_range(1, 2)),
                       2'($urandom_range(0, 3)), "R3 R5 R6 R7 R11 random");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule